// File: doc/BRIEF.md
# Tapped Segmentable Serial Shift Register

This block is a 64-stage serial shift register built from four 16-stage segments. It has one tap at the end of each segment, so the taps sit after stages 16, 32, 48 and 64. A single mode line selects one of two organisations.

With the mode line low, the segments form one continuous chain fed from the serial input. All four taps are driven, and each one shows the last stage of its segment.

With the mode line high, every tap is released to high impedance. The three intermediate taps then act as inputs, so each of the four segments becomes an independent 16-stage chain. The first segment is fed from the serial input and the other three are fed from their tap pins.

Each bidirectional tap is presented as three signals: a registered data value, an output enable, and an external input value. A wrapper can merge these onto an inout pin with a tri-state assignment. A two-channel device is two instances of the block.

Top module: `tsr_top`

## Requirements
- R1: On every rising clock edge `sdin` is captured into stage 1, whatever the level of `split`.
- R2: While `split` is 0, `tap_oe` is all ones, and `tap_q[k]` holds the content of stage 16·(k+1), for k = 0 to 3.
- R3: While `split` is 0, stage 17, 33 and 49 each take the previous content of stage 16, 32 and 48. A bit entered at `sdin` therefore appears on `tap_q[3]` after 64 edges.
- R4: While `split` is 1, `tap_oe` is all zeros, and this includes the output-only final tap `tap_q[3]`.
- R5: While `split` is 1, on each rising edge `tap_in[k]` is loaded into stage 16·(k+1)+1, for k = 0 to 2. A bit driven on `tap_in[k]` appears on `tap_q[k+1]` after 16 edges.
- R6: While `split` is 0, `tap_in` has no effect on the register contents.
- R7: Each rising edge advances every stage by exactly one position in both modes. Between edges the contents do not change.
- R8: `rst_n` low clears all 64 stages to 0 at once, without waiting for a clock edge. Release is expected to be synchronous to the clock.
- R9: A change of `split` alters neither the contents nor the stored data. The new routing applies from the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; the register moves on the rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of all stages |
| sdin | input | 1 | Serial data into stage 1 |
| split | input | 1 | 0: one 64-stage chain with driven taps; 1: four 16-stage chains with released taps |
| tap_in | input | 3 | External values on the intermediate tap pins; used only while `split` is 1 |
| tap_q | output | 4 | Last stage of each segment (stages 16, 32, 48, 64) |
| tap_oe | output | 4 | Output enable per tap, active high |

## Verification
On every cycle, the in-line assertions check the following:
- the head capture of `sdin`;
- the one-stage advance seen at each tap;
- the link between segments, which follows the previous tail in chain mode and the tap input in split mode;
- the release of all taps in split mode.

Some properties span many cycles, and only the bench's reference model can show them:
- the full 64-edge transit in chain mode;
- that `tap_in` is ignored in chain mode;
- that data is preserved across mid-sequence mode changes;
- the asynchronous clear.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  parameter int unsigned TSR_SEG_LEN = 16;
  parameter int unsigned TSR_NUM_SEG = 4;

  typedef enum logic {
    MODE_CHAIN = 1'b0,
    MODE_SPLIT = 1'b1
  } tsr_mode_e;
endpackage

// File: rtl/tsr_segment.sv
module tsr_segment #(
  parameter int unsigned LEN = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           din,
  output logic [LEN-1:0] stages
);
  logic [LEN-1:0] stages_nxt;

  // next state: stage 0 takes din, all others move up by one
  always_comb begin
    stages_nxt = {stages[LEN-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stages <= '0;
    end else begin
      stages <= stages_nxt;
    end
  end
endmodule

// File: rtl/tsr_link.sv
module tsr_link
  import tsr_pkg::*;
#(
  parameter int unsigned NUM_SEG = 4
) (
  input  logic               split,
  input  logic               sdin,
  input  logic [NUM_SEG-2:0] tap_in,
  input  logic [NUM_SEG-1:0] seg_last,
  output logic [NUM_SEG-1:0] seg_din,
  output logic [NUM_SEG-1:0] tap_oe
);
  tsr_mode_e mode;

  always_comb begin
    mode = tsr_mode_e'(split);
  end

  assign seg_din[0] = sdin;

  genvar k;
  generate
    for (k = 1; k < NUM_SEG; k++) begin : g_src
      // chain mode: previous segment tail; split mode: tap pin input
      assign seg_din[k] = (mode == MODE_SPLIT) ? tap_in[k-1] : seg_last[k-1];
    end
    for (k = 0; k < NUM_SEG; k++) begin : g_oe
      assign tap_oe[k] = (mode == MODE_CHAIN);
    end
  endgenerate
endmodule

// File: rtl/tsr_top.sv
module tsr_top
  import tsr_pkg::*;
#(
  parameter int unsigned SEG_LEN = TSR_SEG_LEN,
  parameter int unsigned NUM_SEG = TSR_NUM_SEG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sdin,
  input  logic               split,
  input  logic [NUM_SEG-2:0] tap_in,
  output logic [NUM_SEG-1:0] tap_q,
  output logic [NUM_SEG-1:0] tap_oe
);
  logic [SEG_LEN-1:0] seg_q [NUM_SEG];
  logic [NUM_SEG-1:0] seg_din;
  logic [NUM_SEG-1:0] seg_last;

  tsr_link #(.NUM_SEG(NUM_SEG)) u_link (
    .split    (split),
    .sdin     (sdin),
    .tap_in   (tap_in),
    .seg_last (seg_last),
    .seg_din  (seg_din),
    .tap_oe   (tap_oe)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_SEG; g++) begin : g_seg
      tsr_segment #(.LEN(SEG_LEN)) u_seg (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (seg_din[g]),
        .stages (seg_q[g])
      );
      assign seg_last[g] = seg_q[g][SEG_LEN-1];
      assign tap_q[g]    = seg_last[g];

      AST_TAP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tap_q[g] == $past(seg_q[g][SEG_LEN-2])); // R7

      if (g == 0) begin : g_head
        AST_HEAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
          1'b1 |=> seg_q[0][0] == $past(sdin)); // R1
      end else begin : g_join
        AST_CHAIN_LINK: assert property (@(posedge clk) disable iff (!rst_n)
          !split |=> seg_q[g][0] == $past(tap_q[g-1])); // R3
        AST_SPLIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
          split |=> seg_q[g][0] == $past(tap_in[g-1])); // R5
      end
    end
  endgenerate

  AST_TAP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    split |-> tap_oe == '0); // R4
  AST_TAP_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !split |-> tap_oe == '1); // R2
endmodule

// File: tb/tb_tsr_top.sv
`timescale 1ns/1ps
module tb_tsr_top;
  localparam int SL = 16;
  localparam int NS = 4;
  localparam int TOT = SL * NS;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sdin;
  logic          split;
  logic [NS-2:0] tap_in;
  logic [NS-1:0] tap_q;
  logic [NS-1:0] tap_oe;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;
  logic mdl [TOT];

  always #2.5 clk = ~clk;

  tsr_top dut (
    .clk(clk), .rst_n(rst_n), .sdin(sdin), .split(split),
    .tap_in(tap_in), .tap_q(tap_q), .tap_oe(tap_oe)
  );

  task automatic clear_model();
    for (int i = 0; i < TOT; i++) mdl[i] = 1'b0;
  endtask

  // behavioural reference: index 0 is stage 1
  task automatic model_edge(input logic d, input logic s, input logic [NS-2:0] ti);
    logic nxt [TOT];
    for (int i = 0; i < TOT; i++) begin
      if (i == 0)                   nxt[i] = d;
      else if (s && (i % SL == 0))  nxt[i] = ti[i/SL - 1];
      else                          nxt[i] = mdl[i-1];
    end
    for (int i = 0; i < TOT; i++) mdl[i] = nxt[i];
  endtask

  task automatic compare(input string tag);
    logic [NS-1:0] exp_oe;
    for (int k = 0; k < NS; k++) begin
      n_tests++;
      if (tap_q[k] !== mdl[SL*k + SL - 1]) begin
        n_fail++;
        $display("FAIL %s tap_q[%0d] actual=%b expected=%b", tag, k, tap_q[k], mdl[SL*k+SL-1]);
      end
    end
    exp_oe = split ? '0 : '1;
    n_tests++;
    if (tap_oe !== exp_oe) begin
      n_fail++;
      $display("FAIL %s tap_oe actual=%b expected=%b", split ? "R4" : "R2", tap_oe, exp_oe);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic d, input logic s, input logic [NS-2:0] ti, input string tag);
    sdin = d; split = s; tap_in = ti;
    @(posedge clk);
    model_edge(d, s, ti);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    rst_n = 1'b0; sdin = 1'b0; split = 1'b0; tap_in = '0;
    clear_model();
    repeat (2) @(negedge clk);
    compare("R8");                       // R8 reset state
    rst_n = 1'b1;

    // R3: fill all 64 stages and push them all the way through
    for (int i = 0; i < 2*TOT; i++) step(1'($urandom), 1'b0, '0, "R3");
    // R6: noise on tap pins in chain mode must not matter
    for (int i = 0; i < 40; i++) step(1'($urandom), 1'b0, 3'($urandom), "R6");
    // R5: four independent segments fed through tap pins
    for (int i = 0; i < 40; i++) step(1'($urandom), 1'b1, 3'($urandom), "R5");
    // R1: single pulse on sdin in split mode reaches tap_q[0] after 16 edges
    step(1'b1, 1'b1, 3'b000, "R1");
    for (int i = 0; i < SL; i++) step(1'b0, 1'b1, 3'b000, "R1");
    // R9: mode changes in the middle of a sequence
    for (int i = 0; i < 70; i++) step(1'($urandom), 1'((i / 7) % 2), 3'($urandom), "R9");
    // R7: alternating pattern in both modes
    for (int i = 0; i < 30; i++) step(1'(i % 2), 1'(i >= 15), 3'b101, "R7");

    // R8: asynchronous clear in mid-run
    rst_n = 1'b0;
    #1;
    clear_model();
    compare("R8");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, '0, "R8");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule